// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-word requests from a CPU core into access cycles on an 8-bit multiplexed external bus. The bus has three parts. A shared byte port first carries the low address and then the data. A second byte port holds the high address. Three strobes complete the set: address latch, read and write. Each access runs as a fixed sequence of half-oscillator phases. The block's clock runs at twice the oscillator rate, so every clock tick is one oscillator half (low or high phase). As a result, strobe widths and hold times fall on half-period boundaries.

The core sees a simple handshake. It raises `req` while `ready` is high and gives the address, the direction, the write byte and a flag that marks an instruction fetch. The block then runs the bus cycle and pulses `done` once at the end. For reads, it returns the byte that was captured when the read strobe ended. A strap input chooses where instruction fetches go. With the strap high, a fetch causes no bus activity: the block only pulses `int_fetch` so that the internal program store serves it. With the strap low, fetches go out on the bus. Data accesses always go out on the bus.

With LO = `LO_TICKS` and HI = `HI_TICKS` (ticks per oscillator low and high phase), one strobe width is W = LO + 2*HI ticks, which is one oscillator period plus one high phase. An external cycle has four phases: address (W ticks), address hold (LO), strobe (W) and tail (HI).

Top module: `mxb_ctrl`

## Requirements
- R1: After reset, `ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0 and `int_fetch`=0.
- R2: In an external cycle, `ale` is high for exactly W ticks. The first tick is the one after the accepting clock edge. During those ticks `ad_oe`=1 and `ad_out` equals address bits 7:0.
- R3: After `ale` falls, the low address stays driven for LO more ticks with every strobe inactive. For a read, `ad_oe` then drops before the read strobe asserts.
- R4: `a_hi` equals address bits 15:8 on every tick of the cycle and does not change until the cycle ends.
- R5: In a read cycle, `rd_n` is low for exactly W ticks, starting right after the hold phase. `ad_oe`=0 and `wr_n`=1 for the whole read.
- R6: `rdata` takes the value `ad_in` had on the last tick of the read strobe, and keeps it after `done`.
- R7: In a write cycle, `wr_n` is low for exactly W ticks and `rd_n` stays high. `ad_out` carries the write byte during the strobe and for HI ticks after `wr_n` rises.
- R8: `done` is high for exactly one tick, the last tick of the cycle (tick 2W+LO+HI-1 after acceptance). On the next tick `ready`=1 and `ad_oe`=0.
- R9: With `strap_int`=1, an accepted request with `fetch`=1 produces no bus cycle. `int_fetch` is high for the one tick after the accepting edge, `ready` stays 1, and `ale` and `ad_oe` stay 0.
- R10: With `strap_int`=0, a fetch runs an external read cycle even when `wr`=1. A data request (`fetch`=0) goes to the bus whatever the strap value.
- R11: A request made while `ready`=0 is ignored. The address on `a_hi` and `ad_out` does not change, and no new cycle follows the one in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the oscillator rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, taken when `ready` is high |
| fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| wr | input | 1 | 1 = write (data accesses only) |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write byte |
| strap_int | input | 1 | 1 = fetches served internally, 0 = fetches go to the bus |
| ready | output | 1 | Idle, a request can be accepted |
| done | output | 1 | One-tick pulse on the last tick of a bus cycle |
| rdata | output | 8 | Byte captured at the end of the read strobe |
| int_fetch | output | 1 | One-tick pulse for a fetch served internally |
| ad_in | input | 8 | Shared port, value seen on the pins |
| ad_out | output | 8 | Shared port, value driven |
| ad_oe | output | 1 | Shared port output enable |
| a_hi | output | 16/2 = 8 | High address byte |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench runs a sweep over the direction, fetch flag and strap combinations, with addresses that include all-zero and all-one. On every tick it compares each pin against a phase table it computes from LO and HI. This catches a latch strobe or read/write strobe that is one tick too long or too short. It also catches a shared port that still drives during the read strobe or stops driving before the write data has been held long enough. Read data on `ad_in` changes every tick, so capturing it a tick early or late returns the wrong byte. Further cases send an internal fetch to the bus, treat a fetch with `wr`=1 as a write, or let a request raised in mid-cycle change `a_hi` or start a second cycle; each of these shows up as a pin mismatch.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_STRB = 3'd3,
    PH_TAIL = 3'd4
  } phase_t;

  // one oscillator period plus one high phase, counted in ticks
  function automatic int unsigned strobe_ticks(int unsigned lo, int unsigned hi);
    return lo + 2 * hi;
  endfunction

  function automatic int unsigned phase_ticks(phase_t p, int unsigned lo, int unsigned hi);
    case (p)
      PH_ADDR: return strobe_ticks(lo, hi);
      PH_HOLD: return lo;
      PH_STRB: return strobe_ticks(lo, hi);
      PH_TAIL: return hi;
      default: return 1;
    endcase
  endfunction

  function automatic phase_t phase_after(phase_t p);
    case (p)
      PH_ADDR: return PH_HOLD;
      PH_HOLD: return PH_STRB;
      PH_STRB: return PH_TAIL;
      default: return PH_IDLE;
    endcase
  endfunction

  function automatic int unsigned cycle_ticks(int unsigned lo, int unsigned hi);
    return 2 * strobe_ticks(lo, hi) + lo + hi;
  endfunction

endpackage

// File: rtl/mxb_seq.sv
module mxb_seq
  import mxb_pkg::*;
#(
  parameter int unsigned LO_TICKS = 1,
  parameter int unsigned HI_TICKS = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   last
);
  localparam int unsigned MAXLEN = strobe_ticks(LO_TICKS, HI_TICKS);
  localparam int unsigned CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt;
  phase_t        nxt;
  logic [CW-1:0] nxt_load;

  always_comb begin
    nxt      = phase_after(phase);
    nxt_load = CW'(phase_ticks(nxt, LO_TICKS, HI_TICKS) - 1);
  end

  assign last = (phase != PH_IDLE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase <= PH_ADDR;
        cnt   <= CW'(phase_ticks(PH_ADDR, LO_TICKS, HI_TICKS) - 1);
      end
    end else if (last) begin
      phase <= nxt;
      cnt   <= (nxt == PH_IDLE) ? '0 : nxt_load;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R2: phase counter never leaves its window
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MAXLEN - 1));

  // R8: the tail phase always hands back to idle
  a_r8_tail_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TAIL && last) |=> phase == PH_IDLE);

endmodule

// File: rtl/mxb_pins.sv
module mxb_pins
  import mxb_pkg::*;
#(
  parameter int unsigned LO_TICKS = 1,
  parameter int unsigned HI_TICKS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  phase_t      phase,
  input  logic        last,
  input  logic        is_wr,
  input  logic [15:0] addr_q,
  input  logic [7:0]  wdata_q,
  input  logic [7:0]  ad_in,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic [7:0]  rdata
);
  localparam int unsigned SW = strobe_ticks(LO_TICKS, HI_TICKS);
  localparam int unsigned RW = $clog2(SW + 2);

  logic addr_ph, data_ph;

  always_comb begin
    addr_ph = (phase == PH_ADDR) || (phase == PH_HOLD);
    data_ph = (phase == PH_STRB) || (phase == PH_TAIL);
    ale     = (phase == PH_ADDR);
    rd_n    = !((phase == PH_STRB) && !is_wr);
    wr_n    = !((phase == PH_STRB) && is_wr);
    ad_oe   = addr_ph || (is_wr && data_ph);
    if (addr_ph)                ad_out = addr_q[7:0];
    else if (is_wr && data_ph)  ad_out = wdata_q;
    else                        ad_out = 8'h00;
    a_hi    = addr_q[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                      rdata <= 8'h00;
    else if (phase == PH_STRB && last && !is_wr)     rdata <= ad_in;
  end

  // run-length counters of the strobes, for width checks
  logic [RW-1:0] ale_run, stb_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_run <= '0;
      stb_run <= '0;
    end else begin
      ale_run <= ale ? ale_run + 1'b1 : '0;
      stb_run <= (!rd_n || !wr_n) ? stb_run + 1'b1 : '0;
    end
  end

  a_r2_ale_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ale_run == RW'(SW));
  a_r3_hold_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && rd_n && wr_n));
  a_r5_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> stb_run == RW'(SW));
  a_r5_float_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r7_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (stb_run == RW'(SW) && ad_oe));
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)));

endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl
  import mxb_pkg::*;
#(
  parameter int unsigned LO_TICKS = 1,
  parameter int unsigned HI_TICKS = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        fetch,
  input  logic        wr,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        strap_int,
  output logic        ready,
  output logic        done,
  output logic [7:0]  rdata,
  output logic        int_fetch,
  input  logic [7:0]  ad_in,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n
);
  phase_t      phase;
  logic        last;
  logic        take, go_bus, go_int;
  logic        is_wr_q;
  logic [15:0] addr_q;
  logic [7:0]  wdata_q;

  assign ready  = (phase == PH_IDLE);
  assign take   = req && ready;
  assign go_int = take && fetch && strap_int;
  assign go_bus = take && !go_int;
  assign done   = (phase == PH_TAIL) && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_wr_q   <= 1'b0;
      addr_q    <= 16'h0000;
      wdata_q   <= 8'h00;
      int_fetch <= 1'b0;
    end else begin
      int_fetch <= go_int;
      if (go_bus) begin
        is_wr_q <= wr && !fetch;   // fetches are always reads
        addr_q  <= addr;
        wdata_q <= wdata;
      end
    end
  end

  mxb_seq #(.LO_TICKS(LO_TICKS), .HI_TICKS(HI_TICKS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go_bus),
    .phase (phase),
    .last  (last)
  );

  mxb_pins #(.LO_TICKS(LO_TICKS), .HI_TICKS(HI_TICKS)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .last    (last),
    .is_wr   (is_wr_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .ad_in   (ad_in),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_hi    (a_hi),
    .rdata   (rdata)
  );

  a_r8_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ready && !ad_oe));
  a_r4_high_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(a_hi));
  a_r9_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int_fetch |-> (ready && !ale && !ad_oe));
  a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !done) |=> !ready);

endmodule

// File: tb/mxb_ctrl_bench.sv
module mxb_ctrl_bench;
  localparam int LO = 1;
  localparam int HI = 1;
  localparam int SW = LO + 2 * HI;
  localparam int TOTAL = SW + LO + SW + HI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, fetch = 1'b0, wr = 1'b0, strap_int = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0, ad_in = 8'h0;
  logic ready, done, int_fetch, ad_oe, ale, rd_n, wr_n;
  logic [7:0] rdata, ad_out, a_hi;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mxb_ctrl #(.LO_TICKS(LO), .HI_TICKS(HI)) u_mxb_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .fetch(fetch), .wr(wr), .addr(addr),
    .wdata(wdata), .strap_int(strap_int), .ready(ready), .done(done),
    .rdata(rdata), .int_fetch(int_fetch), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_ext(input logic [15:0] a, input logic [7:0] d, input bit w,
                         input bit f, input bit s, input logic [7:0] seed, input bit poke);
    bit iw;
    iw = w && !f;
    @(negedge clk);
    check(ready == 1'b1, "R11 ready before request", ready, 1);
    req = 1'b1; addr = a; wdata = d; wr = w; fetch = f; strap_int = s;
    for (int k = 0; k < TOTAL; k++) begin
      bit inA, inH, inS, inT, eoe;
      @(negedge clk);
      inA = k < SW;
      inH = (k >= SW) && (k < SW + LO);
      inS = (k >= SW + LO) && (k < 2 * SW + LO);
      inT = (k >= 2 * SW + LO);
      eoe = inA || inH || (iw && (inS || inT));
      check(ale == inA, "R2 ale", ale, inA);
      check(ad_oe == eoe, "R3 ad_oe", ad_oe, eoe);
      if (eoe)
        check(ad_out == ((inA || inH) ? a[7:0] : d), "R7 ad_out", ad_out,
              (inA || inH) ? a[7:0] : d);
      check(rd_n == !(inS && !iw), "R5 rd_n", rd_n, !(inS && !iw));
      check(wr_n == !(inS && iw), "R7 wr_n", wr_n, !(inS && iw));
      check(a_hi == a[15:8], "R4 a_hi", a_hi, a[15:8]);
      check(done == (k == TOTAL - 1), "R8 done", done, k == TOTAL - 1);
      check(ready == 1'b0, "R11 ready in cycle", ready, 0);
      if (poke && k >= 2 && k <= 5) begin
        req = 1'b1; addr = ~a; wdata = ~d;
      end else begin
        req = 1'b0;
      end
      ad_in = seed ^ 8'(k);
    end
    @(negedge clk);
    check(ready == 1'b1, "R8 ready after done", ready, 1);
    check(ad_oe == 1'b0 && ale == 1'b0, "R8 port floats after", {ad_oe, ale}, 0);
    if (!iw)
      check(rdata == (seed ^ 8'(2 * SW + LO - 1)), "R6 rdata", rdata, seed ^ 8'(2 * SW + LO - 1));
    if (poke) begin
      @(negedge clk);
      check(ale == 1'b0 && ready == 1'b1, "R11 no extra cycle", {ale, ready}, 2'b01);
    end
  endtask

  task automatic run_int(input logic [15:0] a, input bit w);
    @(negedge clk);
    req = 1'b1; addr = a; fetch = 1'b1; wr = w; strap_int = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(int_fetch == 1'b1, "R9 int_fetch pulse", int_fetch, 1);
    check(ready == 1'b1 && ale == 1'b0 && ad_oe == 1'b0, "R9 bus quiet", {ready, ale, ad_oe}, 3'b100);
    @(negedge clk);
    check(int_fetch == 1'b0, "R9 pulse one tick", int_fetch, 0);
    check(ale == 1'b0 && rd_n == 1'b1 && wr_n == 1'b1, "R9 no strobes", {ale, rd_n, wr_n}, 3'b011);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(ready == 1'b1 && done == 1'b0 && int_fetch == 1'b0, "R1 reset handshake",
          {ready, done, int_fetch}, 3'b100);
    check(ale == 1'b0 && rd_n == 1'b1 && wr_n == 1'b1 && ad_oe == 1'b0, "R1 reset pins",
          {ale, rd_n, wr_n, ad_oe}, 4'b0110);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = 16'h0040 + 16'(i) * 16'h1357;
      if (i == 3) a = 16'hFFFF;
      if (i == 5) a = 16'h0000;
      if (i[1] && i[2]) run_int(a, i[0]);                      // R9
      else run_ext(a, 8'(8'hA5 ^ 8'(i * 37)), i[0], i[1], i[2], 8'(8'h3C + 8'(i * 11)), 1'b0); // R10
    end
    run_ext(16'h1234, 8'h5A, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b1);  // R11 read
    run_ext(16'hBEEF, 8'h81, 1'b1, 1'b0, 1'b0, 8'h18, 1'b1);  // R11 write
    run_ext(16'h0040, 8'h00, 1'b1, 1'b1, 1'b0, 8'h77, 1'b0);  // R10 fetch with wr
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule